// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives the scan timing of a parallel RGB panel. From a set of programmable fields (active size, front porch, sync width and back porch, for each axis), it counts pixels along a line and lines down a frame. It produces horizontal sync, vertical sync, a data-enable strobe and the current pixel position. A frame interrupt is raised on the first pixel of the first vertical sync line. Software clears it by writing a one. A line-match flag is high for the whole of one programmable line, so that a fetch engine can be woken ahead of the next frame.

Software programs the block through a simple write-only port. Each timing field holds the real count minus one. The live fields are copied into a working set whenever video is off and at every frame boundary while video runs. A change made in the middle of a frame therefore never tears the frame in progress. Every output is registered and active-high. All outputs are forced low while video is disabled.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset every output is low. Setting video enable starts the scan at pixel 0 of line 0: the first valid output cycle shows data-enable high with x and y both zero.
- R2: The horizontal fields sit at addresses 1 (active), 2 (front porch), 3 (sync width) and 4 (back porch). Each holds the count minus one. A line lasts the sum of the four real counts. x runs through the active pixels first, then front porch, then sync, then back porch. hsync is high exactly while x is inside the sync segment.
- R3: The vertical fields sit at addresses 5 (active), 6 (front porch), 7 (sync width) and 8 (back porch), with the same minus-one encoding and the same segment order counted in lines. vsync is high for whole lines inside the vertical sync segment.
- R4: x and y report the current pixel and line. Data-enable is high only when both x and y are inside their active segments.
- R5: The control register (address 0) has video enable at bit 0, global interrupt enable at bit 1 and frame interrupt enable at bit 2. The pending flag sets only when both interrupt enables are on. It sets on pixel 0 of the first vsync line and appears in the same cycle that vsync rises. irq follows the pending flag.
- R6: Writing 1 to bit 0 of the status register (address 10) clears the pending flag. Writing 0 there has no effect. If a clear and a new frame event meet in the same cycle, the event wins.
- R7: The line-match flag is high throughout the line whose index equals the threshold register (address 9).
- R8: Timing fields are taken into the working set only while video is disabled or at the last pixel of a frame. A mid-frame write first shows in the next frame.
- R9: Clearing video enable drives every output low from the second cycle after the write and returns the counters to pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DW | Register write data |
| de_o | output | 1 | Data-enable, high in the active area |
| hsync_o | output | 1 | Horizontal sync, active-high |
| vsync_o | output | 1 | Vertical sync, active-high |
| x_o | output | HW+2 | Current pixel index within the line |
| y_o | output | VW+2 | Current line index within the frame |
| line_hit_o | output | 1 | High during the line equal to the threshold |
| irq_o | output | 1 | Frame interrupt request |

## Verification
All raster outputs and the pending flag are registered from the counters, so each appears one cycle after the counter state it describes. The bench samples on the falling edge and steps a line-and-pixel model in that same frame of reference. A control write issued on one falling edge takes effect in the decode of the following cycle and so changes the outputs two samples later. The disable check and the enable check wait exactly that long. Timing-field writes are issued at least two samples before a frame ends, and the model takes them only when it wraps to the next frame.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_HACT = 4'd1;
  localparam logic [ADDR_W-1:0] A_HBP  = 4'd4;
  localparam logic [ADDR_W-1:0] A_VACT = 4'd5;
  localparam logic [ADDR_W-1:0] A_VBP  = 4'd8;
  localparam logic [ADDR_W-1:0] A_THR  = 4'd9;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd10;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_GIE = 1;
  localparam int CTRL_FIE = 2;

  // segment order along each axis; index into the field arrays
  typedef enum logic [1:0] {
    SEG_ACT   = 2'd0,
    SEG_FRONT = 2'd1,
    SEG_SYNC  = 2'd2,
    SEG_BACK  = 2'd3
  } seg_e;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int DW = 32,
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int TW = VW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 frame_end,
  output logic                 vid_en,
  output logic                 gie,
  output logic                 fie,
  output logic                 clr_req,
  output logic [3:0][HW-1:0]   h_sh,
  output logic [3:0][VW-1:0]   v_sh,
  output logic [TW-1:0]        thr
);
  logic [3:0][HW-1:0] h_live;
  logic [3:0][VW-1:0] v_live;
  logic               hsel, vsel, load;
  logic [1:0]         hidx, vidx;
  logic               unused_wd;

  assign hsel = wr_en && (wr_addr >= A_HACT) && (wr_addr <= A_HBP);
  assign vsel = wr_en && (wr_addr >= A_VACT) && (wr_addr <= A_VBP);
  assign hidx = 2'(wr_addr - A_HACT);
  assign vidx = 2'(wr_addr - A_VACT);
  assign unused_wd = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_en <= 1'b0;
      gie    <= 1'b0;
      fie    <= 1'b0;
      h_live <= '0;
      v_live <= '0;
      thr    <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        vid_en <= wr_data[CTRL_EN];
        gie    <= wr_data[CTRL_GIE];
        fie    <= wr_data[CTRL_FIE];
      end
      if (hsel) h_live[hidx] <= wr_data[HW-1:0];
      if (vsel) v_live[vidx] <= wr_data[VW-1:0];
      if (wr_en && wr_addr == A_THR) thr <= wr_data[TW-1:0];
    end
  end

  // working set follows the live set while idle or at the frame seam
  assign load = !vid_en || frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_sh <= '0;
      v_sh <= '0;
    end else if (load) begin
      h_sh <= h_live;
      v_sh <= v_live;
    end
  end

  assign clr_req = wr_en && (wr_addr == A_STAT) && wr_data[0];

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (vid_en && !frame_end) |=> ($stable(h_sh) && $stable(v_sh)));
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
  parameter int W  = 10,
  parameter int CW = W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                step,
  input  logic [3:0][W-1:0]   fld,
  output logic [CW-1:0]       cnt,
  output logic                is_last,
  output logic                in_act,
  output logic                in_sync,
  output logic                at_sync_start
);
  import dtg_pkg::*;

  logic [CW-1:0] act_end, sync_beg, sync_end, last_idx;

  // each field holds count-1; segments follow active, front, sync, back
  always_comb begin
    act_end  = CW'(fld[SEG_ACT]);
    sync_beg = act_end + CW'(fld[SEG_FRONT]) + CW'(2);
    sync_end = sync_beg + CW'(fld[SEG_SYNC]) + CW'(1);
    last_idx = sync_end + CW'(fld[SEG_BACK]);
  end

  assign is_last       = (cnt == last_idx);
  assign in_act        = (cnt <= act_end);
  assign in_sync       = (cnt >= sync_beg) && (cnt < sync_end);
  assign at_sync_start = (cnt == sync_beg);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (step)   cnt <= is_last ? '0 : cnt + CW'(1);
  end

  // R2 for the pixel axis, R3 for the line axis
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last_idx);
endmodule

// File: rtl/dtg_irq.sv
module dtg_irq (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic gie,
  input  logic fie,
  input  logic clr,
  output logic pend
);
  logic set_c;
  assign set_c = evt && gie && fie;

  always_ff @(posedge clk) begin
    if (rst)        pend <= 1'b0;
    else if (set_c) pend <= 1'b1;
    else if (clr)   pend <= 1'b0;
  end

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_c) |=> !pend);

  // R5
  masked_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend && (!gie || !fie)) |=> !pend);
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 10,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              de_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [HW+1:0]     x_o,
  output logic [VW+1:0]     y_o,
  output logic              line_hit_o,
  output logic              irq_o
);
  localparam int HCW = HW + 2;
  localparam int VCW = VW + 2;

  logic               vid_en, gie, fie, clr_req, frame_end, evt;
  logic [3:0][HW-1:0] h_sh;
  logic [3:0][VW-1:0] v_sh;
  logic [VCW-1:0]     thr;
  logic [HCW-1:0]     hcnt;
  logic [VCW-1:0]     vcnt;
  logic               h_last, h_act, h_sync, h_ss;
  logic               v_last, v_act, v_sync, v_ss;

  dtg_regs #(.DW(DW), .HW(HW), .VW(VW), .TW(VCW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_end(frame_end), .vid_en(vid_en), .gie(gie), .fie(fie),
    .clr_req(clr_req), .h_sh(h_sh), .v_sh(v_sh), .thr(thr)
  );

  dtg_axis #(.W(HW), .CW(HCW)) hax_i (
    .clk(clk), .rst(rst), .run(vid_en), .step(vid_en), .fld(h_sh),
    .cnt(hcnt), .is_last(h_last), .in_act(h_act), .in_sync(h_sync),
    .at_sync_start(h_ss)
  );

  dtg_axis #(.W(VW), .CW(VCW)) vax_i (
    .clk(clk), .rst(rst), .run(vid_en), .step(vid_en && h_last), .fld(v_sh),
    .cnt(vcnt), .is_last(v_last), .in_act(v_act), .in_sync(v_sync),
    .at_sync_start(v_ss)
  );

  assign frame_end = vid_en && h_last && v_last;
  assign evt       = vid_en && (hcnt == '0) && v_ss;

  dtg_irq irq_i (
    .clk(clk), .rst(rst), .evt(evt), .gie(gie), .fie(fie),
    .clr(clr_req), .pend(irq_o)
  );

  logic unused_hss;
  assign unused_hss = h_ss;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o       <= 1'b0;
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      x_o        <= '0;
      y_o        <= '0;
      line_hit_o <= 1'b0;
    end else begin
      de_o       <= vid_en && h_act && v_act;
      hsync_o    <= vid_en && h_sync;
      vsync_o    <= vid_en && v_sync;
      x_o        <= vid_en ? hcnt : '0;
      y_o        <= vid_en ? vcnt : '0;
      line_hit_o <= vid_en && (vcnt == thr);
    end
  end

  // R9
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(vid_en) |-> (!de_o && !hsync_o && !vsync_o && !line_hit_o &&
                        x_o == '0 && y_o == '0));

  // R5
  irq_vsync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> (vsync_o && !$past(vsync_o)));

  // R4
  de_blank_chk: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (!hsync_o && !vsync_o));
endmodule

// File: tb/disp_timing_gen_tb_top.sv
module disp_timing_gen_tb_top;
  localparam int CLK_NS = 10;
  localparam int HW = 10;
  localparam int VW = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          de_o, hsync_o, vsync_o, line_hit_o, irq_o;
  logic [HW+1:0] x_o;
  logic [VW+1:0] y_o;

  disp_timing_gen #(.HW(HW), .VW(VW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .x_o(x_o), .y_o(y_o),
    .line_hit_o(line_hit_o), .irq_o(irq_o)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cur[8];
  int nxt[8];
  int thr_m, ctl_m, p_m, l_m;
  bit pend_m;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic compare(string tag);
    int ha, hf, hs, va, vf, vs;
    bit e_de, e_hs, e_vs;
    ha = cur[0] + 1; hf = cur[1] + 1; hs = cur[2] + 1;
    va = cur[4] + 1; vf = cur[5] + 1; vs = cur[6] + 1;
    e_de = (p_m < ha) && (l_m < va);
    e_hs = (p_m >= ha + hf) && (p_m < ha + hf + hs);
    e_vs = (l_m >= va + vf) && (l_m < va + vf + vs);
    check(de_o == e_de, "R4", {tag, " de"}, int'(de_o), int'(e_de));
    check(int'(x_o) == p_m, "R2", {tag, " x"}, int'(x_o), p_m);
    check(int'(y_o) == l_m, "R3", {tag, " y"}, int'(y_o), l_m);
    check(hsync_o == e_hs, "R2", {tag, " hsync"}, int'(hsync_o), int'(e_hs));
    check(vsync_o == e_vs, "R3", {tag, " vsync"}, int'(vsync_o), int'(e_vs));
    check(line_hit_o == (l_m == thr_m), "R7", {tag, " line_hit"},
          int'(line_hit_o), int'(l_m == thr_m));
    check(irq_o == pend_m, "R5", {tag, " irq"}, int'(irq_o), int'(pend_m));
  endtask

  // one sample step of the raster model
  task automatic advance(bit clr);
    int ht, vt;
    bit evt;
    ht = cur[0] + cur[1] + cur[2] + cur[3] + 4;
    vt = cur[4] + cur[5] + cur[6] + cur[7] + 4;
    p_m++;
    if (p_m == ht) begin
      p_m = 0;
      l_m++;
      if (l_m == vt) begin
        l_m = 0;
        cur = nxt;
      end
    end
    evt = (p_m == 0) && (l_m == cur[4] + cur[5] + 2) && ctl_m[1] && ctl_m[2];
    if (evt) pend_m = 1'b1;
    else if (clr) pend_m = 1'b0;
  endtask

  task automatic track(int n, int w1_at, int w1_a, int w1_d,
                       int w2_at, int w2_a, int w2_d, string tag);
    for (int k = 0; k < n; k++) begin
      int a;
      int d;
      a = -1; d = 0;
      compare(tag);
      if (k == w1_at) begin a = w1_a; d = w1_d; end
      else if (k == w2_at) begin a = w2_a; d = w2_d; end
      if (a >= 0) begin
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = DW'(d);
      end else begin
        wr_en = 1'b0;
      end
      if (a >= 1 && a <= 8) nxt[a-1] = d;
      advance((a == 10) && d[0]);
      if (a == 0) ctl_m = d;
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic configure(int h0, int h1, int h2, int h3,
                           int v0, int v1, int v2, int v3, int thr);
    wr(0, 0);
    wr(1, h0); wr(2, h1); wr(3, h2); wr(4, h3);
    wr(5, v0); wr(6, v1); wr(7, v2); wr(8, v3);
    wr(9, thr);
    wr(10, 1);
    cur[0] = h0; cur[1] = h1; cur[2] = h2; cur[3] = h3;
    cur[4] = v0; cur[5] = v1; cur[6] = v2; cur[7] = v3;
    nxt = cur;
    thr_m = thr; ctl_m = 0; pend_m = 1'b0;
  endtask

  task automatic go(int ctl);
    ctl_m = ctl;
    wr(0, ctl);
    @(negedge clk);
    p_m = 0; l_m = 0;
    // R1 first valid cycle is pixel 0 of line 0
    check(de_o && x_o == '0 && y_o == '0, "R1", "start at origin",
          int'({de_o, x_o}), 1 << (HW + 2));
  endtask

  task automatic t_reset();
    check(!de_o && !hsync_o && !vsync_o && !line_hit_o && !irq_o &&
          x_o == '0 && y_o == '0, "R1", "reset outputs",
          int'({de_o, hsync_o, vsync_o, line_hit_o, irq_o}), 0);
  endtask

  task automatic t_main();
    configure(7, 1, 2, 3, 3, 0, 1, 1, 2);
    go(1);
    track(306, -1, 0, 0, -1, 0, 0, "R2 R3 R4 R7 cfgA");
  endtask

  task automatic t_small();
    // R8 fields written while disabled take effect at once
    configure(2, 0, 0, 0, 1, 0, 0, 0, 0);
    go(1);
    track(90, -1, 0, 0, -1, 0, 0, "R8 minimal fields");
  endtask

  task automatic t_midframe();
    configure(7, 1, 2, 3, 3, 0, 1, 1, 2);
    go(1);
    track(306, 40, 1, 5, -1, 0, 0, "R8 midframe");
  endtask

  task automatic t_irq();
    configure(7, 1, 2, 3, 3, 0, 1, 1, 2);
    go(7);
    track(120, 100, 10, 1, -1, 0, 0, "R6 clear");
    track(200, 117, 10, 1, 130, 10, 0, "R6 set wins and zero write");
  endtask

  task automatic t_irq_masked();
    configure(7, 1, 2, 3, 3, 0, 1, 1, 8);
    go(3);
    track(170, -1, 0, 0, -1, 0, 0, "R5 masked R7 late line");
  endtask

  task automatic t_disable();
    configure(7, 1, 2, 3, 3, 0, 1, 1, 2);
    go(1);
    track(50, -1, 0, 0, -1, 0, 0, "R9 before");
    wr(0, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!de_o && !hsync_o && !vsync_o && !line_hit_o &&
            x_o == '0 && y_o == '0, "R9", "outputs gated",
            int'({de_o, hsync_o, vsync_o, line_hit_o}), 0);
    end
    go(1);
    track(20, -1, 0, 0, -1, 0, 0, "R9 restart");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_main();
    t_small();
    t_midframe();
    t_irq();
    t_irq_masked();
    t_disable();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule